// File: doc/BRIEF.md
# Edge-Triggered Interrupt Request Latch

The block keeps a small set of interrupt request lines and a matching flag register. A requester presents a value together with a select mask in one cycle. Only the lines chosen by the mask take the new value; the others keep their stored level. A selected line that goes from 0 to 1 sets its flag bit. The flag then stays set when the line falls again, so a requester can make a brief request by raising a line and lowering it in a later update.

A software-visible register port reads and writes the flag register and an enable register. A flag bit is cleared only by writing 0 to it. When an update newly sets a flag bit that was clear, that bit is enabled, and the master enable input is high, the block emits a one-cycle wake pulse. It is meant to bring a halted processor back to life. Interrupt vectoring and acknowledge sequencing are left to the processor.

Top module: `irq_edge_latch`

## Requirements
- R1: After synchronous reset the stored lines, the flags and the enable register are all 0, and `wake_o` is 0.
- R2: On a cycle with `upd_valid` high, each stored line whose `upd_mask` bit is 1 takes the matching `upd_value` bit, and each line whose mask bit is 0 keeps its level. Value and mask bits 7 to 5 have no effect. Line i is bit i of `lines_o`, which shows the stored levels one clock after the update.
- R3: A flag bit is set by an update only when its masked value bit is 1 and its stored line was 0. A line already high that is driven high again sets nothing.
- R4: A set flag bit stays set when its line later falls and while updates continue. It is cleared only by a register write.
- R5: A write with `reg_sel`=0 loads `reg_wdata[4:0]` into the flags from the next clock. Writing 0 to a bit clears it, and writing 1 sets it.
- R6: If a flag write clears a bit in the same cycle that an update sets it, the bit ends up set.
- R7: A write with `reg_sel`=1 loads `reg_wdata[4:0]` into the enable register. With `reg_sel`=1, `reg_rdata` is {3'b000, enable}.
- R8: `wake_o` is high for the one cycle after an update in which some line rose whose flag bit was 0 and whose enable bit (before any write in that cycle) was 1, with `master_en` high.
- R9: `wake_o` stays low after an update when no such bit exists: the flag was already set, the bit is not enabled, or `master_en` is low.
- R10: With `reg_sel`=0, `reg_rdata` is {3'b111, flags}, so bits 7 to 5 always read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Line update strobe |
| upd_value | input | 8 | New line levels |
| upd_mask | input | 8 | Lines selected by this update |
| master_en | input | 1 | Master enable for the wake pulse |
| reg_sel | input | 1 | Register select: 0 flags, 1 enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register, read combinationally |
| lines_o | output | 5 | Stored line levels |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The properties assume that `upd_value` and `upd_mask` are only meaningful while `upd_valid` is high, and that a flag clear can come only from a `reg_sel`=0 write. The flag-hold property therefore exempts cycles with such a write. The stimulus changes every input only at the falling edge. It drives each update for exactly one clock, and it puts a flag write in the same cycle as an update only on purpose, to exercise the set-over-clear rule. Values and masks carry junk in bits 7 to 5 so that those bits are shown to be ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int IRQ_LINES  = 5;
    localparam int IRQ_DATA_W = 8;

    typedef enum logic {
        SEL_FLAGS  = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [IRQ_LINES-1:0] value;
        logic [IRQ_LINES-1:0] mask;
        logic                 valid;
    } line_upd_t;

    // Keep only the implemented lines and the selected bits of a request.
    function automatic logic [IRQ_LINES-1:0] sel_bits(
        input logic [IRQ_DATA_W-1:0] value,
        input logic [IRQ_DATA_W-1:0] mask
    );
        logic [IRQ_DATA_W-1:0] both;
        both = value & mask;
        return both[IRQ_LINES-1:0];
    endfunction

endpackage

// File: rtl/irq_line_store.sv
module irq_line_store
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  line_upd_t            upd,
    output logic [IRQ_LINES-1:0] lines_o,
    output logic [IRQ_LINES-1:0] rise_o
);

    logic [IRQ_LINES-1:0] lines_q;
    logic [IRQ_LINES-1:0] eff;

    always_comb begin
        eff    = upd.valid ? (upd.value & upd.mask) : '0;
        rise_o = eff & ~lines_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '0;
        end else if (upd.valid) begin
            lines_q <= (lines_q & ~upd.mask) | eff;
        end
    end

    assign lines_o = lines_q;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IRQ_LINES-1:0] rise,
    input  logic                 wr_en,
    input  logic [IRQ_LINES-1:0] wdata,
    output logic [IRQ_LINES-1:0] flags_o
);

    for (genvar b = 0; b < IRQ_LINES; b++) begin : g_bit
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (rise[b]) begin
                flag_q <= 1'b1;          // an edge beats a write clear
            end else if (wr_en) begin
                flag_q <= wdata[b];
            end
        end
        assign flags_o[b] = flag_q;
    end

endmodule

// File: rtl/irq_wake_gen.sv
module irq_wake_gen
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IRQ_LINES-1:0] rise,
    input  logic [IRQ_LINES-1:0] flags_q,
    input  logic [IRQ_LINES-1:0] enable_q,
    input  logic                 master_en,
    output logic                 wake_o
);

    logic [IRQ_LINES-1:0] fresh;
    logic                 wake_q;

    assign fresh = rise & ~flags_q & enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= master_en && (|fresh);
        end
    end

    assign wake_o = wake_q;

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
    import irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_valid,
    input  logic [IRQ_DATA_W-1:0] upd_value,
    input  logic [IRQ_DATA_W-1:0] upd_mask,
    input  logic                  master_en,
    input  logic                  reg_sel,
    input  logic                  reg_wr,
    input  logic [IRQ_DATA_W-1:0] reg_wdata,
    output logic [IRQ_DATA_W-1:0] reg_rdata,
    output logic [IRQ_LINES-1:0]  lines_o,
    output logic                  wake_o
);

    localparam int PAD_W = IRQ_DATA_W - IRQ_LINES;

    line_upd_t            upd;
    logic [IRQ_LINES-1:0] rise;
    logic [IRQ_LINES-1:0] flags_q;
    logic [IRQ_LINES-1:0] enable_q;
    logic                 flag_wr;
    logic                 en_wr;
    reg_sel_e             sel;

    assign sel       = reg_sel_e'(reg_sel);
    assign flag_wr   = reg_wr && (sel == SEL_FLAGS);
    assign en_wr     = reg_wr && (sel == SEL_ENABLE);
    assign upd.valid = upd_valid;
    assign upd.value = sel_bits(upd_value, upd_mask);
    assign upd.mask  = upd_mask[IRQ_LINES-1:0];

    irq_line_store u_lines (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd),
        .lines_o (lines_o),
        .rise_o  (rise)
    );

    irq_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .wr_en   (flag_wr),
        .wdata   (reg_wdata[IRQ_LINES-1:0]),
        .flags_o (flags_q)
    );

    irq_wake_gen u_wake (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .flags_q   (flags_q),
        .enable_q  (enable_q),
        .master_en (master_en),
        .wake_o    (wake_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (en_wr) begin
            enable_q <= reg_wdata[IRQ_LINES-1:0];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAGS:  reg_rdata = {{PAD_W{1'b1}}, flags_q};
            SEL_ENABLE: reg_rdata = {{PAD_W{1'b0}}, enable_q};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_edge_latch_chk.sv
module irq_edge_latch_chk
    import irq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  upd_valid,
    input logic [IRQ_DATA_W-1:0] upd_value,
    input logic [IRQ_DATA_W-1:0] upd_mask,
    input logic                  master_en,
    input logic                  reg_sel,
    input logic                  reg_wr,
    input logic [IRQ_DATA_W-1:0] reg_rdata,
    input logic [IRQ_LINES-1:0]  lines_o,
    input logic [IRQ_LINES-1:0]  flags_q,
    input logic                  wake_o
);

    logic [IRQ_LINES-1:0] exp_rise;
    logic [IRQ_LINES-1:0] m5;
    logic                 flag_clear_possible;

    assign m5       = upd_mask[IRQ_LINES-1:0];
    assign exp_rise = upd_valid ? (upd_value[IRQ_LINES-1:0] & m5 & ~lines_o) : '0;
    assign flag_clear_possible = reg_wr && !reg_sel;

    // R2: lines outside the mask keep their level
    p_unmasked_hold_r2: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ((lines_o & ~$past(m5)) == ($past(lines_o) & ~$past(m5))));

    // R2: no update, no line change
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(lines_o));

    // R4: flags never fall without a flag write
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !flag_clear_possible |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R6: a rising edge always lands in the flags, write or not
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(exp_rise)) == $past(exp_rise)));

    // R9: master enable low means no wake
    p_no_wake_master_off_r9: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> !wake_o);

    // R8: wake only follows an update
    p_wake_after_update_r8: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(upd_valid));

    // R10: flag reads carry ones above the lines
    p_flag_pad_r10: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (reg_rdata[IRQ_DATA_W-1:IRQ_LINES] == '1));

endmodule

bind irq_edge_latch irq_edge_latch_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_value (upd_value),
    .upd_mask  (upd_mask),
    .master_en (master_en),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .lines_o   (lines_o),
    .flags_q   (flags_q),
    .wake_o    (wake_o)
);

// File: tb/test_irq_edge_latch.sv
module test_irq_edge_latch;

    logic       clk = 1'b0;
    logic       rst;
    logic       upd_valid;
    logic [7:0] upd_value;
    logic [7:0] upd_mask;
    logic       master_en;
    logic       reg_sel;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [4:0] lines_o;
    logic       wake_o;

    always #10 clk = ~clk;   // 50 MHz

    irq_edge_latch i_irq_edge_latch (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .upd_value (upd_value),
        .upd_mask  (upd_mask),
        .master_en (master_en),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lines_o   (lines_o),
        .wake_o    (wake_o)
    );

    typedef struct packed {
        logic [7:0] rdata;
        logic [4:0] lines;
        logic       wake;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    logic [4:0] m_lines = '0;
    logic [4:0] m_flags = '0;
    logic [4:0] m_en    = '0;

    task automatic step(input logic v, input logic [7:0] val, input logic [7:0] msk,
                        input logic men, input logic wr, input logic sel,
                        input logic [7:0] wd, input string tag);
        logic [4:0] eff, rise, base;
        logic       wk;
        exp_t       e;
        @(negedge clk);
        upd_valid = v; upd_value = val; upd_mask = msk; master_en = men;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        eff  = v ? (val[4:0] & msk[4:0]) : 5'd0;
        rise = eff & ~m_lines;
        if (v) m_lines = (m_lines & ~msk[4:0]) | eff;
        wk   = men && (|(rise & ~m_flags & m_en));
        base = (wr && !sel) ? wd[4:0] : m_flags;
        m_flags = base | rise;
        if (wr && sel) m_en = wd[4:0];
        e.rdata = sel ? {3'b000, m_en} : {3'b111, m_flags};
        e.lines = m_lines;
        e.wake  = wk;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        #5;
        if (!rst && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e.rdata || lines_o !== e.lines || wake_o !== e.wake) begin
                errors++;
                $display("FAIL %s: rdata=%h lines=%h wake=%b expected rdata=%h lines=%h wake=%b",
                         t, reg_rdata, lines_o, wake_o, e.rdata, e.lines, e.wake);
            end
        end
    end

    initial begin
        rst = 1'b1; upd_valid = 0; upd_value = 0; upd_mask = 0; master_en = 0;
        reg_sel = 0; reg_wr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 and R10: reset state
        step(0, 8'h00, 8'h00, 0, 0, 0, 8'h00, "R1/R10 flags after reset");
        step(0, 8'h00, 8'h00, 0, 0, 1, 8'h00, "R1 enable after reset");
        step(0, 8'h00, 8'h00, 1, 1, 1, 8'hFF, "R7 enable write");
        step(1, 8'h01, 8'h01, 1, 0, 0, 8'h00, "R3/R8 rise line0 wakes");
        step(1, 8'h00, 8'h01, 1, 0, 0, 8'h00, "R4 flag held after line falls");
        step(1, 8'h06, 8'h02, 1, 0, 0, 8'h00, "R2 only masked line1");
        step(1, 8'hFF, 8'hE4, 1, 0, 0, 8'h00, "R2 high bits ignored");
        step(1, 8'h06, 8'h06, 1, 0, 0, 8'h00, "R3/R9 level high no set");
        step(0, 8'h00, 8'h00, 1, 1, 0, 8'h00, "R5 flag clear by write");
        step(1, 8'h02, 8'h02, 1, 0, 0, 8'h00, "R3 held line no re-set");
        step(1, 8'h00, 8'h06, 1, 0, 1, 8'h00, "R2 lines drop");
        step(1, 8'h08, 8'h08, 1, 1, 0, 8'h00, "R6/R8 set wins over clear");
        step(1, 8'h10, 8'h10, 0, 0, 0, 8'h00, "R9 master off no wake");
        step(0, 8'h00, 8'h00, 1, 1, 1, 8'h00, "R7 enable cleared");
        step(0, 8'h00, 8'h00, 1, 1, 0, 8'h00, "R5 clear all flags");
        step(1, 8'h01, 8'h01, 1, 0, 0, 8'h00, "R9 disabled bit no wake");
        step(0, 8'h00, 8'h00, 1, 1, 1, 8'h1F, "R7 enable all");
        step(1, 8'h00, 8'h01, 1, 0, 0, 8'h00, "R4 line0 falls flag stays");
        step(1, 8'h01, 8'h01, 1, 0, 0, 8'h00, "R9 flag already set no wake");
        step(0, 8'h00, 8'h00, 1, 1, 0, 8'h15, "R5 flag write ones");
        step(0, 8'h00, 8'h00, 1, 0, 0, 8'h00, "R10 flag read pad");
        step(0, 8'h00, 8'h00, 1, 0, 0, 8'h00, "R8 wake one cycle wide");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL monitor: %0d items left, expected 0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule